// File: doc/BRIEF.md
# UART Transmit Sequencer over a Register Bus

This block is a bus master that sends a string of bytes through an existing 16550-style UART register block. It does not serialise bits. For each character it polls the UART line status register over a single-outstanding read/write port until the transmit holding register is empty. It then writes the character into the holding register. A controlling state machine hands it a command through a two-bit level enable and follows its progress on a two-bit status code.

The payload comes from one of two places. The first is a local data register, captured when the command is accepted. The second is a word-aligned memory region, which the block reads over the same bus as 32-bit words. Each payload byte can go out raw or as two uppercase ASCII hex digits; hex conversion applies from a selectable byte index onward. A carriage return and line feed can follow the payload.

A typical controller runs this loop:
1. Wait for status 0.
2. Set the parameters and raise enable to 1.
3. Wait for status 2.
4. Drop enable.

Top module: `uart_tx_sequencer`

## Requirements
- R1: After reset, status is 0 and no bus request is valid. While status is 0 the block issues no bus request.
- R2: Command 1 given while status is 0 makes status 1 at the next clock edge. Status becomes 2 once the last character has been written. Status holds 2 while the command stays nonzero, and returns to 0 at the first clock edge after the command is 0.
- R3: Command 2 given while status is 0 makes status 3 at the next clock edge, with no bus access. Status holds 3 until the command returns to 0, then goes to 0 at the next edge.
- R4: With source select 0, payload byte k is bits [8k+7:8k] of the data input captured when the command was accepted, sent in rising k order.
- R5: With source select 1, payload byte k is lane k mod 4 (bits [8(k mod 4)+7 : 8(k mod 4)]) of the word read from the start address plus 4·floor(k/4). Each needed word is read exactly once, in rising address order, and every memory read address is a multiple of 4.
- R6: Exactly the requested number of payload bytes is sent. A length of 0 sends no payload.
- R7: With hex mode on, each payload byte whose index is at or above the hex start index goes out as two uppercase ASCII hex digits (0x30–0x39, 0x41–0x46), high nibble first. Bytes before that index, and all bytes with hex mode off, go out unchanged.
- R8: With the newline flag set, 0x0D and then 0x0A are written after the payload, including when the length is 0.
- R9: Every character write goes to the UART base address (holding register, offset 0x00), with the character in write data bits [7:0] and zeros above. Each write is preceded by a read of base + 0x14 whose returned bit 5 was 1, with no other access in between. A reply with bit 5 at 0 leads to another status read.
- R10: A bus request holds its address, write flag and write data unchanged while it waits for ready. At most one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_en | input | 2 | Command level: 0 none, 1 transmit, 2 receive |
| src_sel | input | 1 | Payload source: 0 data register, 1 memory |
| tx_data | input | 8*BUF_BYTES | Local payload bytes, byte 0 in the lowest bits |
| tx_addr | input | 32 | Memory start address, multiple of 4 |
| tx_len | input | LEN_W | Payload length in bytes |
| hex_en | input | 1 | Send payload bytes as hex digits from the hex start index |
| hex_start | input | LEN_W | First payload index that is hex converted |
| nl_en | input | 1 | Append CR and LF after the payload |
| status | output | 2 | 0 ready, 1 busy, 2 done, 3 done without received data |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_write | output | 1 | 1 write, 0 read |
| bus_req_addr | output | 32 | Request address |
| bus_req_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | Read data valid |
| bus_rsp_rdata | input | 32 | Read data |

## Verification
Status checks are timed from the falling edge where the command changes. Status must read 1 or 3 at the next falling edge, and 0 one falling edge after the command drops. Status 2 is sampled on each of several falling edges while the command is held. Character content is not tied to cycle counts, because the slave inserts ready stalls and a varying number of holding-register-busy replies. Instead, the bench logs every accepted write and every memory read at the clock edge where the handshake completes. It compares those logs with the byte stream computed from the command once status reports 2. A read reply is due one cycle after the read handshake, so the slave's model of "transmit register empty granted" is exact at the moment each write is accepted.

// File: rtl/uts_pkg.sv
package uts_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_NEXT,
    S_FETCH_REQ,
    S_FETCH_WAIT,
    S_POLL_REQ,
    S_POLL_WAIT,
    S_WR_REQ,
    S_DONE,
    S_DONE_RX
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_PAY,
    PH_CR,
    PH_LF,
    PH_END
  } tail_phase_e;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_TX   = 2'd1;
  localparam logic [1:0] CMD_RX   = 2'd2;

  localparam logic [1:0] STAT_READY  = 2'd0;
  localparam logic [1:0] STAT_BUSY   = 2'd1;
  localparam logic [1:0] STAT_DONE   = 2'd2;
  localparam logic [1:0] STAT_NODATA = 2'd3;

  localparam logic [31:0] LSR_OFFSET = 32'h14;
  localparam logic [31:0] THR_OFFSET = 32'h00;
  localparam int          THRE_BIT   = 5;

  localparam logic [7:0] CHAR_CR = 8'h0D;
  localparam logic [7:0] CHAR_LF = 8'h0A;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction

endpackage

// File: rtl/uts_byte_pick.sv
module uts_byte_pick #(
  parameter int BUF_BYTES = 8,
  parameter int LEN_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [8*BUF_BYTES-1:0] data_in,
  input  logic                   word_load,
  input  logic [31:0]            word_in,
  input  logic                   src_mem,
  input  logic [LEN_W-1:0]       idx,
  output logic [7:0]             byte_out
);

  localparam int BUF_W = 8 * BUF_BYTES;

  logic [BUF_W-1:0] data_q;
  logic [31:0]      word_q;
  logic [7:0]       buf_lane [BUF_BYTES];
  logic [7:0]       word_lane [4];
  logic [7:0]       reg_byte;
  logic [7:0]       mem_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cfg_load) begin
      data_q <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_load) begin
      word_q <= word_in;
    end
  end

  genvar g;
  generate
    for (g = 0; g < BUF_BYTES; g++) begin : g_buf_lane
      assign buf_lane[g] = data_q[8*g +: 8];
    end
    for (g = 0; g < 4; g++) begin : g_word_lane
      assign word_lane[g] = word_q[8*g +: 8];
    end
  endgenerate

  always_comb begin
    reg_byte = 8'h00;
    for (int i = 0; i < BUF_BYTES; i++) begin
      if (idx == LEN_W'(i)) reg_byte = buf_lane[i];
    end
  end

  assign mem_byte = word_lane[idx[1:0]];
  assign byte_out = src_mem ? mem_byte : reg_byte;

  AST_WORD_LOAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |-> (idx[1:0] == 2'b00)); // R5

endmodule

// File: rtl/uts_char_gen.sv
module uts_char_gen
  import uts_pkg::*;
(
  input  tail_phase_e phase,
  input  logic [7:0]  byte_in,
  input  logic        hex_on,
  input  logic        nib_lo,
  output logic [7:0]  ch
);

  logic [3:0] nib;

  assign nib = nib_lo ? byte_in[3:0] : byte_in[7:4];

  always_comb begin
    case (phase)
      PH_CR:   ch = CHAR_CR;
      PH_LF:   ch = CHAR_LF;
      default: ch = hex_on ? nib_to_ascii(nib) : byte_in;
    endcase
  end

endmodule

// File: rtl/uts_seq_fsm.sv
module uts_seq_fsm
  import uts_pkg::*;
#(
  parameter int          LEN_W     = 8,
  parameter logic [31:0] UART_BASE = 32'hFFC0_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_en,
  input  logic              src_sel_i,
  input  logic [31:0]       addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              hex_en_i,
  input  logic [LEN_W-1:0]  hex_start_i,
  input  logic              nl_i,
  input  logic [7:0]        ch_i,
  output logic [1:0]        status,
  output logic              cfg_load,
  output logic              word_load,
  output logic              src_mem,
  output logic [LEN_W-1:0]  idx,
  output tail_phase_e       phase,
  output logic              hex_now,
  output logic              nib_lo,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [31:0]       bus_req_addr,
  output logic [31:0]       bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic              thre_i
);

  localparam logic [31:0] LSR_ADDR = UART_BASE + LSR_OFFSET;
  localparam logic [31:0] THR_ADDR = UART_BASE + THR_OFFSET;

  seq_state_e       state_q, state_d;
  tail_phase_e      phase_q, phase_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic             nib_q, nib_d;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] hstart_q;
  logic [31:0]      addr_q;
  logic             src_q, hex_q, nl_q;
  logic [LEN_W-1:0] idx_inc;

  assign idx_inc = idx_q + 1'b1;
  assign hex_now = hex_q && (idx_q >= hstart_q);
  assign src_mem = src_q;
  assign idx     = idx_q;
  assign phase   = phase_q;
  assign nib_lo  = nib_q;

  // next-state process
  always_comb begin
    state_d       = state_q;
    phase_d       = phase_q;
    idx_d         = idx_q;
    nib_d         = nib_q;
    cfg_load      = 1'b0;
    word_load     = 1'b0;
    bus_req_valid = 1'b0;
    bus_req_write = 1'b0;
    bus_req_addr  = LSR_ADDR;
    bus_req_wdata = '0;
    case (state_q)
      S_IDLE: begin
        if (cmd_en == CMD_TX) begin
          cfg_load = 1'b1;
          idx_d    = '0;
          nib_d    = 1'b0;
          if (len_i != '0) phase_d = PH_PAY;
          else if (nl_i)   phase_d = PH_CR;
          else             phase_d = PH_END;
          state_d  = S_NEXT;
        end else if (cmd_en == CMD_RX) begin
          state_d = S_DONE_RX;
        end
      end
      S_NEXT: begin
        case (phase_q)
          PH_END: state_d = S_DONE;
          PH_PAY: begin
            if (src_q && !nib_q && (idx_q[1:0] == 2'b00)) state_d = S_FETCH_REQ;
            else                                            state_d = S_POLL_REQ;
          end
          default: state_d = S_POLL_REQ;
        endcase
      end
      S_FETCH_REQ: begin
        bus_req_valid = 1'b1;
        bus_req_addr  = addr_q + 32'(idx_q);
        if (bus_req_ready) state_d = S_FETCH_WAIT;
      end
      S_FETCH_WAIT: begin
        if (bus_rsp_valid) begin
          word_load = 1'b1;
          state_d   = S_POLL_REQ;
        end
      end
      S_POLL_REQ: begin
        bus_req_valid = 1'b1;
        bus_req_addr  = LSR_ADDR;
        if (bus_req_ready) state_d = S_POLL_WAIT;
      end
      S_POLL_WAIT: begin
        if (bus_rsp_valid) state_d = thre_i ? S_WR_REQ : S_POLL_REQ;
      end
      S_WR_REQ: begin
        bus_req_valid = 1'b1;
        bus_req_write = 1'b1;
        bus_req_addr  = THR_ADDR;
        bus_req_wdata = {24'h0, ch_i};
        if (bus_req_ready) begin
          state_d = S_NEXT;
          case (phase_q)
            PH_PAY: begin
              if (hex_now && !nib_q) begin
                nib_d = 1'b1;
              end else begin
                nib_d = 1'b0;
                idx_d = idx_inc;
                if (idx_inc == len_q) phase_d = nl_q ? PH_CR : PH_END;
              end
            end
            PH_CR:   phase_d = PH_LF;
            default: phase_d = PH_END;
          endcase
        end
      end
      S_DONE, S_DONE_RX: begin
        if (cmd_en == CMD_NONE) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      phase_q <= PH_END;
      idx_q   <= '0;
      nib_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      nib_q   <= nib_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      hstart_q <= '0;
      addr_q   <= '0;
      src_q    <= 1'b0;
      hex_q    <= 1'b0;
      nl_q     <= 1'b0;
    end else if (cfg_load) begin
      len_q    <= len_i;
      hstart_q <= hex_start_i;
      addr_q   <= addr_i;
      src_q    <= src_sel_i;
      hex_q    <= hex_en_i;
      nl_q     <= nl_i;
    end
  end

  always_comb begin
    case (state_q)
      S_IDLE:    status = STAT_READY;
      S_DONE:    status = STAT_DONE;
      S_DONE_RX: status = STAT_NODATA;
      default:   status = STAT_BUSY;
    endcase
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status == STAT_READY) |-> !bus_req_valid); // R1

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status == STAT_DONE && cmd_en != CMD_NONE) |=> (status == STAT_DONE)); // R2

  AST_RX_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (status == STAT_NODATA) |-> !bus_req_valid); // R3

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_write && bus_req_addr != LSR_ADDR) |-> (bus_req_addr[1:0] == 2'b00)); // R5

  AST_HEX_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_write && phase_q == PH_PAY && hex_now) |->
    ((bus_req_wdata[7:0] >= 8'h30 && bus_req_wdata[7:0] <= 8'h39) ||
     (bus_req_wdata[7:0] >= 8'h41 && bus_req_wdata[7:0] <= 8'h46))); // R7

  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_write) |-> (bus_req_addr == THR_ADDR && bus_req_wdata[31:8] == 24'h0)); // R9

  AST_WRITE_AFTER_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WR_REQ && $past(state_q) != S_WR_REQ) |-> $past(bus_rsp_valid && thre_i)); // R9

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=>
    (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_write) && $stable(bus_req_wdata))); // R10

endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
  import uts_pkg::*;
#(
  parameter int          BUF_BYTES = 8,
  parameter int          LEN_W     = 8,
  parameter logic [31:0] UART_BASE = 32'hFFC0_2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cmd_en,
  input  logic                   src_sel,
  input  logic [8*BUF_BYTES-1:0] tx_data,
  input  logic [31:0]            tx_addr,
  input  logic [LEN_W-1:0]       tx_len,
  input  logic                   hex_en,
  input  logic [LEN_W-1:0]       hex_start,
  input  logic                   nl_en,
  output logic [1:0]             status,
  output logic                   bus_req_valid,
  input  logic                   bus_req_ready,
  output logic                   bus_req_write,
  output logic [31:0]            bus_req_addr,
  output logic [31:0]            bus_req_wdata,
  input  logic                   bus_rsp_valid,
  input  logic [31:0]            bus_rsp_rdata
);

  logic             rst_meta, rst_sync;
  logic             cfg_load, word_load, src_mem, hex_now, nib_lo;
  logic [LEN_W-1:0] idx;
  tail_phase_e      phase;
  logic [7:0]       cur_byte;
  logic [7:0]       ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  uts_seq_fsm #(
    .LEN_W     (LEN_W),
    .UART_BASE (UART_BASE)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync),
    .cmd_en        (cmd_en),
    .src_sel_i     (src_sel),
    .addr_i        (tx_addr),
    .len_i         (tx_len),
    .hex_en_i      (hex_en),
    .hex_start_i   (hex_start),
    .nl_i          (nl_en),
    .ch_i          (ch),
    .status        (status),
    .cfg_load      (cfg_load),
    .word_load     (word_load),
    .src_mem       (src_mem),
    .idx           (idx),
    .phase         (phase),
    .hex_now       (hex_now),
    .nib_lo        (nib_lo),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_req_write (bus_req_write),
    .bus_req_addr  (bus_req_addr),
    .bus_req_wdata (bus_req_wdata),
    .bus_rsp_valid (bus_rsp_valid),
    .thre_i        (bus_rsp_rdata[THRE_BIT])
  );

  uts_byte_pick #(
    .BUF_BYTES (BUF_BYTES),
    .LEN_W     (LEN_W)
  ) u_pick (
    .clk       (clk),
    .rst_n     (rst_sync),
    .cfg_load  (cfg_load),
    .data_in   (tx_data),
    .word_load (word_load),
    .word_in   (bus_rsp_rdata),
    .src_mem   (src_mem),
    .idx       (idx),
    .byte_out  (cur_byte)
  );

  uts_char_gen u_chr (
    .phase   (phase),
    .byte_in (cur_byte),
    .hex_on  (hex_now),
    .nib_lo  (nib_lo),
    .ch      (ch)
  );

endmodule

// File: tb/uart_tx_sequencer_tb.sv
module uart_tx_sequencer_tb;

  localparam int          BUF_BYTES = 8;
  localparam int          LEN_W     = 8;
  localparam logic [31:0] BASE      = 32'hFFC0_2000;
  localparam logic [31:0] LSR       = BASE + 32'h14;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [1:0]             cmd_en = 2'd0;
  logic                   src_sel = 1'b0;
  logic [8*BUF_BYTES-1:0] tx_data = '0;
  logic [31:0]            tx_addr = '0;
  logic [LEN_W-1:0]       tx_len = '0;
  logic                   hex_en = 1'b0;
  logic [LEN_W-1:0]       hex_start = '0;
  logic                   nl_en = 1'b0;
  logic [1:0]             status;
  logic                   bus_req_valid, bus_req_write;
  logic                   bus_req_ready = 1'b0;
  logic [31:0]            bus_req_addr, bus_req_wdata;
  logic                   bus_rsp_valid;
  logic [31:0]            bus_rsp_rdata;

  always #2 clk = ~clk;

  uart_tx_sequencer #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .UART_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .src_sel(src_sel), .tx_data(tx_data),
    .tx_addr(tx_addr), .tx_len(tx_len), .hex_en(hex_en), .hex_start(hex_start),
    .nl_en(nl_en), .status(status), .bus_req_valid(bus_req_valid),
    .bus_req_ready(bus_req_ready), .bus_req_write(bus_req_write),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata));

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done_flag = 1'b0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[7:0] ^ 8'hC3, a[9:2] + 8'h20, a[7:0] + 8'h0D, a[9:2] * 8'd7};
  endfunction

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 10) ? (8'h30 + 8'(n)) : (8'h41 + 8'(n) - 8'd10);
  endfunction

  // behavioural slave: UART registers and memory
  logic [7:0]  wr_log [4096];
  logic [31:0] rd_log [4096];
  int          wr_n = 0, rd_n = 0, lsr_n = 0;
  int          busy_left = 0;
  bit          thre_ok = 1'b0;
  int          thre_viol = 0, wr_addr_bad = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rsp_valid <= 1'b0;
      bus_rsp_rdata <= '0;
      thre_ok       <= 1'b0;
    end else begin
      bus_rsp_valid <= 1'b0;
      if (bus_req_valid && bus_req_ready) begin
        if (bus_req_write) begin
          if (bus_req_addr != BASE || bus_req_wdata[31:8] != 0) wr_addr_bad <= wr_addr_bad + 1;
          if (!thre_ok) thre_viol <= thre_viol + 1;
          thre_ok <= 1'b0;
          wr_log[wr_n % 4096] <= bus_req_wdata[7:0];
          wr_n <= wr_n + 1;
          busy_left <= wr_n % 3;
        end else if (bus_req_addr == LSR) begin
          lsr_n <= lsr_n + 1;
          bus_rsp_valid <= 1'b1;
          if (busy_left > 0) begin
            bus_rsp_rdata <= 32'hFFFF_FFDF;
            busy_left <= busy_left - 1;
            thre_ok <= 1'b0;
          end else begin
            bus_rsp_rdata <= 32'h0000_0061;
            thre_ok <= 1'b1;
          end
        end else begin
          rd_log[rd_n % 4096] <= bus_req_addr;
          rd_n <= rd_n + 1;
          bus_rsp_valid <= 1'b1;
          bus_rsp_rdata <= mem_word(bus_req_addr);
          thre_ok <= 1'b0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    bus_req_ready <= ((cyc % 5) != 3);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    finish_run();
  end

  task automatic run_tx(input bit src, input int len, input bit hx, input int hs,
                        input bit nl, input logic [63:0] dat, input logic [31:0] adr);
    logic [7:0] exp_c [64];
    string      exp_r [64];
    int ne = 0;
    int w0, r0, to;
    logic [7:0] b;
    for (int k = 0; k < len; k++) begin
      if (src) b = 8'(mem_word(adr + 32'(4 * (k / 4))) >> (8 * (k % 4)));
      else     b = dat[8*k +: 8];
      if (hx && k >= hs) begin
        exp_c[ne] = hexc(b[7:4]); exp_r[ne] = "R7"; ne++;
        exp_c[ne] = hexc(b[3:0]); exp_r[ne] = "R7"; ne++;
      end else begin
        exp_c[ne] = b; exp_r[ne] = src ? "R5" : "R4"; ne++;
      end
    end
    if (nl) begin
      exp_c[ne] = 8'h0D; exp_r[ne] = "R8"; ne++;
      exp_c[ne] = 8'h0A; exp_r[ne] = "R8"; ne++;
    end
    w0 = wr_n; r0 = rd_n;
    src_sel = src; tx_len = LEN_W'(len); hex_en = hx; hex_start = LEN_W'(hs);
    nl_en = nl; tx_data = dat; tx_addr = adr;
    cmd_en = 2'd1;
    @(negedge clk);
    check(status == 2'd1, "R2", "status busy after enable", 32'(status), 32'd1);
    to = 0;
    while (status != 2'd2 && to < 4000) begin @(negedge clk); to++; end
    check(status == 2'd2, "R2", "status done", 32'(status), 32'd2);
    check(wr_n - w0 == ne, "R6", "character count", 32'(wr_n - w0), 32'(ne));
    for (int i = 0; i < ne && i < wr_n - w0; i++)
      check(wr_log[(w0 + i) % 4096] == exp_c[i], exp_r[i], $sformatf("char %0d", i),
            32'(wr_log[(w0 + i) % 4096]), 32'(exp_c[i]));
    check(rd_n - r0 == (src ? (len + 3) / 4 : 0), "R5", "memory read count",
          32'(rd_n - r0), 32'(src ? (len + 3) / 4 : 0));
    for (int j = 0; j < rd_n - r0 && j < (len + 3) / 4; j++)
      check(rd_log[(r0 + j) % 4096] == adr + 32'(4 * j), "R5", "memory read address",
            rd_log[(r0 + j) % 4096], adr + 32'(4 * j));
    repeat (2) begin
      @(negedge clk);
      check(status == 2'd2, "R2", "status held at done", 32'(status), 32'd2);
    end
    cmd_en = 2'd0;
    @(negedge clk);
    check(status == 2'd0, "R2", "status ready after enable low", 32'(status), 32'd0);
  endtask

  initial begin
    int run = 0;
    logic [63:0] d;
    int w0, r0, l0;
    repeat (3) @(negedge clk);
    check(status == 2'd0, "R1", "reset status", 32'(status), 32'd0);
    check(bus_req_valid == 1'b0, "R1", "reset request", 32'(bus_req_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(status == 2'd0 && !bus_req_valid, "R1", "idle after reset release",
          {30'd0, status}, 32'd0);

    // R3: receive command
    w0 = wr_n; r0 = rd_n; l0 = lsr_n;
    cmd_en = 2'd2;
    @(negedge clk);
    check(status == 2'd3, "R3", "receive status", 32'(status), 32'd3);
    repeat (3) @(negedge clk);
    check(status == 2'd3, "R3", "receive status held", 32'(status), 32'd3);
    check((wr_n + rd_n + lsr_n) == (w0 + r0 + l0), "R3", "no bus access on receive",
          32'(wr_n + rd_n + lsr_n), 32'(w0 + r0 + l0));
    cmd_en = 2'd0;
    @(negedge clk);
    check(status == 2'd0, "R3", "ready after receive", 32'(status), 32'd0);

    // sweep: source, length, hex start (or hex off), newline
    for (int s = 0; s < 2; s++)
      for (int len = 0; len <= BUF_BYTES; len++)
        for (int h = -1; h <= len; h++)
          for (int nl = 0; nl < 2; nl++) begin
            for (int k = 0; k < 8; k++) d[8*k +: 8] = 8'(run * 29 + k * 37 + 10);
            run_tx(s[0], len, h >= 0, (h < 0) ? 0 : h, nl[0], d,
                   32'h1000_0000 + 32'(run * 16));
            run++;
          end

    check(thre_viol == 0, "R9", "writes without empty holding register",
          32'(thre_viol), 32'd0);
    check(wr_addr_bad == 0, "R9", "write address or upper data", 32'(wr_addr_bad), 32'd0);
    finish_run();
  end

endmodule